// File: doc/BRIEF.md
# Public Input Segment Parser

This block sits at the front of an authenticated-cipher core and turns the public input word stream into typed payload beats for the cipher datapath. Words of width `W` arrive over a valid/ready channel. Each input starts with a 32-bit instruction. Encrypt and decrypt instructions are followed by a run of 32-bit segment headers, each with its payload words. A header carries a type code, end-of-type and end-of-input flags, and a length in bytes. When `W` is below 32, each 32-bit item spans several words, and the most significant word comes first.

Each decoded header is presented downstream as a single descriptor beat. Its payload words follow as data beats, which repeat the type and flags. The final data beat carries a last flag and a byte-valid mask. The parser zeroes every byte lane outside that mask, so a zero-length segment shows up as a descriptor beat with no data beats after it. The decoded operation is reported on a separate code output together with a one-cycle strobe.

Top module: `pub_seg_parser`

## Requirements
- R1: After reset, `inReady` is high, `outValid` is low and `opCode` is 0 (none).
- R2: Bits [31:28] of a completed instruction are decoded as follows: 0010 gives `opCode`=1 (encrypt), 0011 gives 2 (decrypt), 0100 gives 3 (load key), 0111 gives 4 (activate key), and any other code gives 5 (reserved). `opStrobe` is high for exactly one cycle per decoded instruction.
- R3: After an activate-key, load-key or reserved instruction, the next input item is taken as another instruction. After an encrypt or decrypt instruction, the next items are segment headers.
- R4: A header spans ceil(32/W) words, most significant word first. Its fields are type [31:28], EOI bit 27, EOT bit 26 and length [15:0]. Each header produces one beat with `outHdr`=1, and that beat carries `outType`, `outEoi`, `outEot` and `outLen`.
- R5: A segment of length L produces ceil(L/(W/8)) data beats with `outHdr`=0, carrying the same type, flags and length. `outLast` is 1 only on the final data beat and is 0 on descriptor beats.
- R6: `outMask` bit W/8-1 is the most significant byte lane, which holds the first byte. The mask is all ones except on the final beat, where the top (L mod (W/8)) lanes are set, and 0 there means a full word.
- R7: Data bytes in lanes whose mask bit is 0 are driven as zero, whatever the input held in those lanes.
- R8: A segment of length 0 produces its descriptor beat and no data beats.
- R9: While a data beat is offered and `outReady` is low, `inReady` is low, so no word is lost or repeated. A descriptor beat stays unchanged until it is accepted.
- R10: After the last data beat of a segment with EOI set, or after the descriptor of a zero-length segment with EOI set, the next input item is parsed as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | W | Public input word |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Parser accepts the input word |
| outData | output | W | Payload word, unused lanes zeroed |
| outMask | output | W/8 | Byte-valid mask, MSB is the first lane |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Datapath accepts the beat |
| outHdr | output | 1 | Beat is a segment descriptor |
| outType | output | 4 | Segment type code |
| outEot | output | 1 | Last segment of its type |
| outEoi | output | 1 | Last segment of the input |
| outLen | output | 16 | Segment length in bytes |
| outLast | output | 1 | Final data beat of the segment |
| opCode | output | 3 | Decoded operation |
| opStrobe | output | 1 | Pulses when an instruction is decoded |

## Verification
The bench targets odd-length segments whose final input word carries junk in its unused lane. A design that forgot to zero that lane, or that set the mask from the wrong end, would pass the junk through or report a full word. Zero-length AD, ciphertext and message segments come next. A parser that tried to read one payload word for these would swallow the following header and lose framing. Random back-pressure is applied during payload, where a parser that kept `inReady` high would drop words. Finally, reserved and load-key instructions check that a design treating them as encrypt would misread the next instruction as a header.

// File: rtl/pub_seg_pkg.sv
package pub_seg_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ENC    = 3'd1,
    OP_DEC    = 3'd2,
    OP_LDKEY  = 3'd3,
    OP_ACTKEY = 3'd4,
    OP_RSVD   = 3'd5
  } opKind_e;

  typedef enum logic [1:0] {
    ST_INSTR,
    ST_HDR,
    ST_DESC,
    ST_DATA
  } parseSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // an instruction/header word was accepted
    logic loadHdr;  // the header is complete, capture its fields
    logic consume;  // a payload beat moved downstream
  } dpCtrl_t;

  function automatic opKind_e decodeOp(input logic [3:0] code);
    case (code)
      4'b0010: return OP_ENC;
      4'b0011: return OP_DEC;
      4'b0100: return OP_LDKEY;
      4'b0111: return OP_ACTKEY;
      default: return OP_RSVD;
    endcase
  endfunction

endpackage

// File: rtl/pub_seg_ctrl.sv
module pub_seg_ctrl
  import pub_seg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic [3:0]  opNibble,
  input  logic        lenZero,
  input  logic        lastBeat,
  input  logic        hdrEoi,
  output dpCtrl_t     ctrl,
  output logic        inReady,
  output logic        outValid,
  output logic        outHdr,
  output logic        outLast,
  output logic [2:0]  opCode,
  output logic        opStrobe
);

  localparam int HW = (32 + W - 1) / W;
  localparam int CW = (HW > 1) ? $clog2(HW) : 1;

  parseSt_e       st;
  logic [CW-1:0]  wordCnt;
  opKind_e        opReg;
  opKind_e        opNext;
  logic           lastWord;
  logic           acceptIn;
  logic           collecting;

  assign lastWord   = (wordCnt == CW'(HW - 1));
  assign collecting = (st == ST_INSTR) || (st == ST_HDR);
  assign acceptIn   = inValid && inReady;
  assign opNext     = decodeOp(opNibble);
  assign opCode     = opReg;

  always_comb begin
    inReady      = collecting || ((st == ST_DATA) && outReady);
    outValid     = (st == ST_DESC) || ((st == ST_DATA) && inValid);
    outHdr       = (st == ST_DESC);
    outLast      = (st == ST_DATA) && lastBeat;
    ctrl.shiftEn = acceptIn && collecting;
    ctrl.loadHdr = acceptIn && (st == ST_HDR) && lastWord;
    ctrl.consume = (st == ST_DATA) && inValid && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_INSTR;
      wordCnt  <= '0;
      opReg    <= OP_NONE;
      opStrobe <= 1'b0;
    end else begin
      opStrobe <= 1'b0;
      if (ctrl.shiftEn) wordCnt <= lastWord ? '0 : wordCnt + 1'b1;
      case (st)
        ST_INSTR: if (acceptIn && lastWord) begin
          opReg    <= opNext;
          opStrobe <= 1'b1;
          if (opNext == OP_ENC || opNext == OP_DEC) st <= ST_HDR;
        end
        ST_HDR:  if (acceptIn && lastWord) st <= ST_DESC;
        ST_DESC: if (outReady) st <= !lenZero ? ST_DATA : (hdrEoi ? ST_INSTR : ST_HDR);
        ST_DATA: if (ctrl.consume && lastBeat) st <= hdrEoi ? ST_INSTR : ST_HDR;
        default: st <= ST_INSTR;
      endcase
    end
  end

endmodule

// File: rtl/pub_seg_dp.sv
module pub_seg_dp
  import pub_seg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtrl_t        ctrl,
  input  logic [W-1:0]   inData,
  output logic [3:0]     opNibble,
  output logic [3:0]     hdrType,
  output logic           hdrEoi,
  output logic           hdrEot,
  output logic [15:0]    hdrLen,
  output logic           lenZero,
  output logic           lastBeat,
  output logic [W/8-1:0] mask,
  output logic [W-1:0]   dataMasked
);

  localparam int          BPW   = W / 8;
  localparam logic [15:0] BPW16 = 16'(BPW);

  logic [31:0] wordFull;
  logic [15:0] remBytes;
  logic        unusedRsvd;

  generate
    if (W == 32) begin : g_wide
      assign wordFull = inData;
    end else begin : g_narrow
      logic [31-W:0] shReg;
      assign wordFull = {shReg, inData};
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             shReg <= '0;
        else if (ctrl.shiftEn) shReg <= wordFull[31-W:0];
      end
    end
  endgenerate

  assign opNibble   = wordFull[31:28];
  assign unusedRsvd = ^wordFull[25:16];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrType  <= '0;
      hdrEoi   <= 1'b0;
      hdrEot   <= 1'b0;
      hdrLen   <= '0;
      remBytes <= '0;
    end else if (ctrl.loadHdr) begin
      hdrType  <= wordFull[31:28];
      hdrEoi   <= wordFull[27];
      hdrEot   <= wordFull[26];
      hdrLen   <= wordFull[15:0];
      remBytes <= wordFull[15:0];
    end else if (ctrl.consume) begin
      remBytes <= lastBeat ? 16'd0 : remBytes - BPW16;
    end
  end

  assign lenZero  = (remBytes == 16'd0);
  assign lastBeat = (remBytes <= BPW16);

  // lane k counts from the most significant byte
  generate
    for (genvar k = 0; k < BPW; k++) begin : g_lane
      assign mask[BPW-1-k] = !lastBeat || (remBytes > 16'(k));
      assign dataMasked[W-1-8*k -: 8] = mask[BPW-1-k] ? inData[W-1-8*k -: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/pub_seg_parser.sv
module pub_seg_parser
  import pub_seg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [W-1:0]   inData,
  input  logic           inValid,
  output logic           inReady,
  output logic [W-1:0]   outData,
  output logic [W/8-1:0] outMask,
  output logic           outValid,
  input  logic           outReady,
  output logic           outHdr,
  output logic [3:0]     outType,
  output logic           outEot,
  output logic           outEoi,
  output logic [15:0]    outLen,
  output logic           outLast,
  output logic [2:0]     opCode,
  output logic           opStrobe
);

  dpCtrl_t    ctrl;
  logic [3:0] opNibble;
  logic       lenZero;
  logic       lastBeat;

  pub_seg_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .opNibble (opNibble),
    .lenZero  (lenZero),
    .lastBeat (lastBeat),
    .hdrEoi   (outEoi),
    .ctrl     (ctrl),
    .inReady  (inReady),
    .outValid (outValid),
    .outHdr   (outHdr),
    .outLast  (outLast),
    .opCode   (opCode),
    .opStrobe (opStrobe)
  );

  pub_seg_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .inData     (inData),
    .opNibble   (opNibble),
    .hdrType    (outType),
    .hdrEoi     (outEoi),
    .hdrEot     (outEot),
    .hdrLen     (outLen),
    .lenZero    (lenZero),
    .lastBeat   (lastBeat),
    .mask       (outMask),
    .dataMasked (outData)
  );

endmodule

// File: rtl/pub_seg_parser_chk.sv
module pub_seg_parser_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           inReady,
  input logic [W-1:0]   outData,
  input logic [W/8-1:0] outMask,
  input logic           outValid,
  input logic           outReady,
  input logic           outHdr,
  input logic [15:0]    outLen,
  input logic           outLast
);

  localparam int BPW = W / 8;

  logic [W-1:0]   laneMask;
  logic [BPW-1:0] invMask;
  logic           dataBeat;

  always_comb begin
    for (int k = 0; k < BPW; k++) laneMask[k*8 +: 8] = {8{outMask[k]}};
  end
  assign invMask  = ~outMask;
  assign dataBeat = outValid && !outHdr;

  // R6: mask is a non-empty run of lanes starting at the MSB
  assert_mask_shape_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataBeat |-> (outMask != '0) && ((invMask & (invMask + 1'b1)) == '0));

  // R6: only the final beat may be partial
  assert_full_mid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataBeat && !outLast) |-> (&outMask));

  // R7: masked-off lanes carry zero
  assert_zero_lanes_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataBeat |-> ((outData & ~laneMask) == '0));

  // R5: descriptor beats never carry the last flag
  assert_hdr_not_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHdr) |-> !outLast);

  // R9: input stalls while a payload beat is blocked
  assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataBeat && !outReady) |-> !inReady);

  // R9: a blocked descriptor stays put
  assert_desc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHdr && !outReady) |=> (outValid && outHdr && $stable(outLen)));

endmodule

bind pub_seg_parser pub_seg_parser_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outData  (outData),
  .outMask  (outMask),
  .outValid (outValid),
  .outReady (outReady),
  .outHdr   (outHdr),
  .outLen   (outLen),
  .outLast  (outLast)
);

// File: tb/pub_seg_parser_tb.sv
`timescale 1ns/1ps
module pub_seg_parser_tb;

  localparam int W = 16;

  typedef struct packed {
    logic        hdr;
    logic [3:0]  typ;
    logic        eot;
    logic        eoi;
    logic [15:0] len;
    logic [15:0] data;
    logic [1:0]  mask;
    logic        last;
  } beat_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  inData = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [W-1:0]  outData;
  logic [1:0]    outMask;
  logic          outValid;
  logic          outReady = 1'b1;
  logic          outHdr;
  logic [3:0]    outType;
  logic          outEot;
  logic          outEoi;
  logic [15:0]   outLen;
  logic          outLast;
  logic [2:0]    opCode;
  logic          opStrobe;

  int nChecks = 0;
  int nErrors = 0;
  bit bpMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  beat_t      gotB [0:127];
  beat_t      expB [0:127];
  int         nGot = 0;
  int         nExp = 0;
  logic [2:0] gotOp [0:15];
  logic [2:0] expOp [0:15];
  int         nGotOp = 0;
  int         nExpOp = 0;

  always #2 clk = ~clk;

  pub_seg_parser #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outMask(outMask), .outValid(outValid), .outReady(outReady),
    .outHdr(outHdr), .outType(outType), .outEot(outEot), .outEoi(outEoi),
    .outLen(outLen), .outLast(outLast), .opCode(opCode), .opStrobe(opStrobe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // downstream ready, random when back-pressure is on
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = bpMode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor, mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && outReady && nGot < 128) begin
        gotB[nGot] = '{hdr: outHdr, typ: outType, eot: outEot, eoi: outEoi, len: outLen,
                       data: outHdr ? 16'h0 : outData, mask: outHdr ? 2'b00 : outMask,
                       last: outLast};
        nGot++;
      end
      if (opStrobe && nGotOp < 16) begin
        gotOp[nGotOp] = opCode;
        nGotOp++;
      end
      if (bpMode && outValid && !outHdr && !outReady)
        chk(!inReady, "R9", "inReady during blocked payload", 64'(inReady), 64'd0);
    end
  end

  task automatic sendWord(input logic [W-1:0] w);
    inData  = w;
    inValid = 1'b1;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inData  = 16'hBEEF;
  endtask

  task automatic sendInstr(input logic [3:0] code, input logic [2:0] expCode);
    sendWord({code, 12'h000});
    sendWord(16'h0000);
    expOp[nExpOp] = expCode;
    nExpOp++;
  endtask

  task automatic sendSeg(input logic [3:0] typ, input bit eot, input bit eoi,
                         input int len, input logic [7:0] seed);
    beat_t b;
    int nw;
    sendWord({typ, eoi, eot, 2'b00, 8'h00});
    sendWord(16'(len));
    b = '0;
    b.hdr = 1'b1; b.typ = typ; b.eot = eot; b.eoi = eoi; b.len = 16'(len);
    expB[nExp] = b; nExp++;
    nw = (len + 1) / 2;
    for (int i = 0; i < nw; i++) begin
      logic [7:0] b0;
      logic [7:0] b1;
      bit half;
      b0 = seed + 8'(2 * i);
      b1 = seed + 8'(2 * i + 1);
      half = (i == nw - 1) && (len % 2 == 1);
      sendWord({b0, half ? 8'hEE : b1});
      b.hdr  = 1'b0;
      b.data = {b0, half ? 8'h00 : b1};
      b.mask = half ? 2'b10 : 2'b11;
      b.last = (i == nw - 1);
      expB[nExp] = b; nExp++;
    end
  endtask

  task automatic finishScenario(input string tag);
    repeat (20) @(posedge clk);
    #1;
    chk(nGot == nExp, tag, "beat count", 64'(nGot), 64'(nExp));
    for (int i = 0; i < nExp; i++)
      chk(i < nGot && gotB[i] == expB[i], tag, $sformatf("beat %0d", i),
          64'(gotB[i]), 64'(expB[i]));
    chk(nGotOp == nExpOp, tag, "op count", 64'(nGotOp), 64'(nExpOp));
    for (int i = 0; i < nExpOp; i++)
      chk(i < nGotOp && gotOp[i] == expOp[i], tag, $sformatf("op %0d", i),
          64'(gotOp[i]), 64'(expOp[i]));
    nGot = 0; nExp = 0; nGotOp = 0; nExpOp = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(inReady == 1'b1, "R1", "inReady", 64'(inReady), 64'd1);
    chk(outValid == 1'b0, "R1", "outValid", 64'(outValid), 64'd0);
    chk(opCode == 3'd0, "R1", "opCode", 64'(opCode), 64'd0);
    @(posedge clk); #1;
  endtask

  // activate key then encrypt, odd tails with junk in the spare lane
  task automatic testEncBasic();
    sendInstr(4'b0111, 3'd4);
    sendInstr(4'b0010, 3'd1);
    sendSeg(4'b1100, 1'b1, 1'b0, 4, 8'h10);
    sendSeg(4'b0001, 1'b1, 1'b0, 3, 8'h20);
    sendSeg(4'b0100, 1'b1, 1'b1, 5, 8'h30);
    finishScenario("R2 R3 R4 R5 R6 R7 R10");
  endtask

  // decrypt with empty AD and empty ciphertext
  task automatic testDecEmpty();
    sendInstr(4'b0011, 3'd2);
    sendSeg(4'b1100, 1'b1, 1'b0, 2, 8'h40);
    sendSeg(4'b0001, 1'b1, 1'b0, 0, 8'h00);
    sendSeg(4'b0101, 1'b1, 1'b0, 0, 8'h00);
    sendSeg(4'b1101, 1'b1, 1'b1, 3, 8'h50);
    finishScenario("R8 R4 R10");
  endtask

  // split AD and a long message under random back-pressure
  task automatic testBackpressure();
    bpMode = 1'b1;
    sendInstr(4'b0010, 3'd1);
    sendSeg(4'b0001, 1'b0, 1'b0, 1, 8'h60);
    sendSeg(4'b0001, 1'b1, 1'b0, 2, 8'h70);
    sendSeg(4'b0100, 1'b1, 1'b1, 9, 8'h80);
    finishScenario("R9 R5");
    bpMode = 1'b0;
  endtask

  // standalone instructions, then an input made of one empty segment
  task automatic testStandalone();
    sendInstr(4'b0100, 3'd3);
    sendInstr(4'b0101, 3'd5);
    sendInstr(4'b1111, 3'd5);
    sendInstr(4'b0010, 3'd1);
    sendSeg(4'b0100, 1'b1, 1'b1, 0, 8'h00);
    sendInstr(4'b0111, 3'd4);
    finishScenario("R3 R2 R8 R10");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testEncBasic();
    testDecEmpty();
    testBackpressure();
    testStandalone();
    summary();
    $finish;
  end

  initial begin
    #400000;
    nChecks++;
    nErrors++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

endmodule